// File: doc/BRIEF.md
# Pipelined Radix-4 Signed-Digit Adder

This block adds two operands written as radix-4 signed-digit vectors, where every digit ranges from -3 to +3. Because the digit set is redundant, the addition needs no carry chain. Each digit position first reduces the sum of its two input digits to a small transfer digit and a small interim digit. It then adds the interim digit to the transfer that arrives from the position directly below. The worst-case logic depth is therefore the same for any operand width.

A register stage sits between the two steps, and the result is also registered. A new operand pair can be accepted on every clock, and each result appears two cycles after its operands. The result has one more digit than the operands. The top digit is the transfer out of the highest position. An encoding that lies outside the digit set is reported alongside the result it corrupts.

Top module: `qsd_pipe_adder`

## Requirements
- R1: Every digit is a 3-bit two's complement field in the range -3..+3. Operand digit i occupies bits [3i+2:3i] of `in_a` and `in_b`, and result digit i occupies bits [3i+2:3i] of `out_sum`. With NDIG operand digits there are NDIG+1 result digits.
- R2: At each position, the pair sum p (from -6 to +6) is split into a transfer t and an interim digit s, with p = 4t + s, |t| <= 1 and |s| <= 2. The split is as follows. Pair sums of 3 or more give t = +1 and s = p-4. Pair sums of -3 or less give t = -1 and s = p+4. Every other pair sum gives t = 0 and s = p.
- R3: Result digit 0 equals s0. Result digit i, for 0 < i < NDIG, equals s_i + t_(i-1). Result digit NDIG equals t_(NDIG-1), sign-extended to 3 bits.
- R4: When no operand digit is illegal, no result digit takes the code 100 (-4), so every result digit stays in the range -3..+3.
- R5: For legal operands, the radix-4 value of `out_sum` (the sum of d_i * 4^i) equals the sum of the radix-4 values of `in_a` and `in_b`.
- R6: `out_valid` is high in exactly the cycle that comes two rising edges after a cycle with `in_valid` high. Operand pairs may arrive on consecutive cycles, and each result appears in order.
- R7: While `rst_n` is low, `out_valid`, `out_bad` and `out_sum` read zero.
- R8: If either operand of a pair holds the code 100 in any digit, `out_bad` is high together with that pair's `out_valid`. For a pair of legal operands, `out_bad` is low.
- R9: A cycle with `in_valid` low does not alter `out_sum`, whatever `in_a` and `in_b` carry, and it produces no `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the operand pair in this cycle |
| in_a | input | 3*NDIG | First operand, signed-digit vector |
| in_b | input | 3*NDIG | Second operand, signed-digit vector |
| out_valid | output | 1 | Result valid, two cycles after `in_valid` |
| out_sum | output | 3*(NDIG+1) | Sum, signed-digit vector |
| out_bad | output | 1 | An operand of this result held an illegal digit |

## Verification
The bench drives every pair of digit values into both the lowest and the highest position. Pair sums of exactly +/-2 and +/-3 are therefore all covered. A split threshold placed one step off would produce a digit of +/-3 in the interim and then push the next result digit to -4. A wrong sign extension of the transfer would corrupt the top result digit. Both failures break the value check. Operands made entirely of +3 or entirely of -3 test every transfer path at once. A stream of pairs on consecutive cycles exposes a latency error or a missing enable, because the results would come out shifted. Idle cycles with garbage on the operand inputs show whether an ungated register lets the result drift. An illegal digit in a single operand shows whether the error flag follows its own result.

// File: rtl/qsd_pkg.sv
package qsd_pkg;
  localparam int DIG_W  = 3;
  localparam int XFER_W = 2;

  typedef logic signed [DIG_W-1:0]  digit_t;
  typedef logic signed [XFER_W-1:0] xfer_t;

  localparam digit_t DIG_ILLEGAL = 3'b100;
endpackage

// File: rtl/qsd_split.sv
module qsd_split
  import qsd_pkg::*;
(
  input  digit_t a_i,
  input  digit_t b_i,
  output xfer_t  t_o,
  output digit_t s_o,
  output logic   bad_o
);
  logic signed [3:0] pair;
  logic signed [3:0] lowered;
  logic signed [3:0] raised;

  always_comb begin
    pair    = {a_i[2], a_i} + {b_i[2], b_i};
    lowered = pair - 4'sd4;
    raised  = pair + 4'sd4;
    bad_o   = (a_i == DIG_ILLEGAL) || (b_i == DIG_ILLEGAL);
    if (pair >= 4'sd3) begin
      t_o = 2'sb01;
      s_o = lowered[2:0];
    end else if (pair <= -4'sd3) begin
      t_o = 2'sb11;
      s_o = raised[2:0];
    end else begin
      t_o = '0;
      s_o = pair[2:0];
    end
  end

  // Bounds and value identity of the split (R2)
  always_comb begin
    if (!bad_o) begin
      assert_split_bound_R2: assert ((t_o != 2'sb10) && (int'(s_o) <= 2) && (int'(s_o) >= -2));
      assert_split_value_R2: assert ((int'(t_o) * 4 + int'(s_o)) == int'(pair));
    end
  end
endmodule

// File: rtl/qsd_merge.sv
module qsd_merge
  import qsd_pkg::*;
(
  input  digit_t s_i,
  input  xfer_t  t_i,
  output digit_t r_o
);
  always_comb begin
    r_o = s_i + {t_i[1], t_i};
  end
endmodule

// File: rtl/qsd_pipe_adder.sv
module qsd_pipe_adder
  import qsd_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [NDIG*DIG_W-1:0]       in_a,
  input  logic [NDIG*DIG_W-1:0]       in_b,
  output logic                        out_valid,
  output logic [(NDIG+1)*DIG_W-1:0]   out_sum,
  output logic                        out_bad
);
  localparam int IN_W  = NDIG * DIG_W;
  localparam int OUT_W = (NDIG + 1) * DIG_W;
  localparam int TR_W  = NDIG * XFER_W;

  // step one outputs
  logic [TR_W-1:0] xfer_d;
  logic [IN_W-1:0] part_d;
  logic [NDIG-1:0] bad_d;

  // stage-one registers
  logic [TR_W-1:0] xfer_q;
  logic [IN_W-1:0] part_q;
  logic            bad1_q;
  logic            v1_q;

  // step two
  logic [OUT_W-1:0] sum_d;
  logic             ld1;
  logic             ld2;

  genvar g;
  generate
    for (g = 0; g < NDIG; g++) begin : g_split
      qsd_split u_split (
        .a_i  (in_a[g*DIG_W +: DIG_W]),
        .b_i  (in_b[g*DIG_W +: DIG_W]),
        .t_o  (xfer_d[g*XFER_W +: XFER_W]),
        .s_o  (part_d[g*DIG_W +: DIG_W]),
        .bad_o(bad_d[g])
      );
    end

    assign sum_d[0 +: DIG_W] = part_q[0 +: DIG_W];

    for (g = 1; g < NDIG; g++) begin : g_merge
      qsd_merge u_merge (
        .s_i(part_q[g*DIG_W +: DIG_W]),
        .t_i(xfer_q[(g-1)*XFER_W +: XFER_W]),
        .r_o(sum_d[g*DIG_W +: DIG_W])
      );
    end

    assign sum_d[NDIG*DIG_W +: DIG_W] =
      {xfer_q[TR_W-1], xfer_q[TR_W-1 -: XFER_W]};
  endgenerate

  // clock enables
  always_comb begin
    ld1 = in_valid;
    ld2 = v1_q;
  end

  // stage-one register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q <= '0;
      part_q <= '0;
      bad1_q <= 1'b0;
      v1_q   <= 1'b0;
    end else begin
      v1_q <= ld1;
      if (ld1) begin
        xfer_q <= xfer_d;
        part_q <= part_d;
        bad1_q <= |bad_d;
      end
    end
  end

  // output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sum   <= '0;
      out_bad   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= ld2;
      if (ld2) begin
        out_sum <= sum_d;
        out_bad <= bad1_q;
      end else begin
        out_bad <= 1'b0;
      end
    end
  end

  // Assertions
  assert_stage1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> v1_q);
  assert_stage2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(v1_q));
  assert_bad_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_bad |-> out_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |=> $stable(out_sum));

  generate
    for (g = 0; g <= NDIG; g++) begin : g_chk
      assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_bad) |-> (out_sum[g*DIG_W +: DIG_W] != DIG_ILLEGAL));
    end
  endgenerate
endmodule

// File: tb/qsd_pipe_adder_tb.sv
module qsd_pipe_adder_tb;
  localparam int ND = 4;
  localparam int IW = 3 * ND;
  localparam int OW = 3 * (ND + 1);

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [IW-1:0] in_a;
  logic [IW-1:0] in_b;
  logic          out_valid;
  logic [OW-1:0] out_sum;
  logic          out_bad;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  qsd_pipe_adder #(.NDIG(ND)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_sum(out_sum), .out_bad(out_bad)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int dg(input logic [OW-1:0] v, input int i);
    logic signed [2:0] x;
    x = v[3*i +: 3];
    return int'(x);
  endfunction

  function automatic longint val(input logic [OW-1:0] v, input int n);
    longint acc = 0;
    longint w = 1;
    for (int i = 0; i < n; i++) begin
      acc += longint'(dg(v, i)) * w;
      w *= 4;
    end
    return acc;
  endfunction

  // expected sum from the split table of R2 and the combine rule of R3
  function automatic logic [OW-1:0] model(input logic [IW-1:0] a, input logic [IW-1:0] b);
    int t[ND];
    int s[ND];
    int p;
    int d;
    logic [OW-1:0] r;
    for (int i = 0; i < ND; i++) begin
      p = dg(OW'(a), i) + dg(OW'(b), i);
      case (p)
        -6: begin t[i] = -1; s[i] = -2; end
        -5: begin t[i] = -1; s[i] = -1; end
        -4: begin t[i] = -1; s[i] =  0; end
        -3: begin t[i] = -1; s[i] =  1; end
         3: begin t[i] =  1; s[i] = -1; end
         4: begin t[i] =  1; s[i] =  0; end
         5: begin t[i] =  1; s[i] =  1; end
         6: begin t[i] =  1; s[i] =  2; end
        default: begin t[i] = 0; s[i] = p; end
      endcase
    end
    for (int i = 0; i < ND; i++) begin
      d = s[i] + ((i > 0) ? t[i-1] : 0);
      r[3*i +: 3] = d[2:0];
    end
    d = t[ND-1];
    r[3*ND +: 3] = d[2:0];
    return r;
  endfunction

  function automatic logic [IW-1:0] put(input int pos, input int v);
    logic [IW-1:0] r = '0;
    r[3*pos +: 3] = v[2:0];
    return r;
  endfunction

  task automatic check_result(input logic [IW-1:0] a, input logic [IW-1:0] b, input string tag);
    logic [OW-1:0] e;
    e = model(a, b);
    check(out_valid == 1'b1, "R6", {tag, " valid"}, out_valid, 1);
    check(out_sum == e, "R3", {tag, " digits"}, out_sum, e);
    check(val(out_sum, ND+1) == val(OW'(a), ND) + val(OW'(b), ND), "R5", {tag, " value"},
          val(out_sum, ND+1), val(OW'(a), ND) + val(OW'(b), ND));
    for (int i = 0; i <= ND; i++)
      check(out_sum[3*i +: 3] != 3'b100, "R4", {tag, " digit range"}, dg(out_sum, i), 0);
    check(out_bad == 1'b0, "R8", {tag, " bad low"}, out_bad, 0);
  endtask

  // one pair, checked at its output cycle
  task automatic apply(input logic [IW-1:0] a, input logic [IW-1:0] b, input string tag);
    in_a = a; in_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R6", {tag, " early valid"}, out_valid, 0);
    @(negedge clk);
    check_result(a, b, tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7", "reset valid", out_valid, 0);
    check(out_bad == 1'b0, "R7", "reset bad", out_bad, 0);
    check(out_sum == '0, "R7", "reset sum", out_sum, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_directed();
    logic [IW-1:0] a;
    logic [IW-1:0] b;
    // R1: field layout, digit i at bits [3i+2:3i]
    a = put(0, 1) | put(1, 0) | put(2, 3) | put(3, 1);
    b = put(0, 3) | put(1, 2) | put(2, 2) | put(3, 1);
    apply(a, b, "R1 mixed");
    a = '0; b = '0;
    for (int i = 0; i < ND; i++) begin a |= put(i, 3); b |= put(i, 3); end
    apply(a, b, "R1 all plus3");
    check(val(out_sum, ND+1) == 510, "R1", "all plus3 total", val(out_sum, ND+1), 510);
    a = '0; b = '0;
    for (int i = 0; i < ND; i++) begin a |= put(i, -3); b |= put(i, -3); end
    apply(a, b, "R1 all minus3");
    check(dg(out_sum, ND) == -1, "R3", "top digit from transfer", dg(out_sum, ND), -1);
    apply('0, '0, "R5 zero");
  endtask

  task automatic t_exhaustive();
    for (int pos = 0; pos < ND; pos += ND - 1)
      for (int x = -3; x <= 3; x++)
        for (int y = -3; y <= 3; y++)
          apply(put(pos, x), put(pos, y), "R2 digit pair");
  endtask

  task automatic t_random();
    logic [IW-1:0] a;
    logic [IW-1:0] b;
    for (int k = 0; k < 150; k++) begin
      for (int i = 0; i < ND; i++) begin
        a[3*i +: 3] = 3'($signed(int'($urandom_range(0, 6)) - 3));
        b[3*i +: 3] = 3'($signed(int'($urandom_range(0, 6)) - 3));
      end
      apply(a, b, "R5 random");
    end
  endtask

  task automatic t_stream();
    logic [IW-1:0] sa[8];
    logic [IW-1:0] sb[8];
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < ND; i++) begin
        sa[k][3*i +: 3] = 3'($signed(int'($urandom_range(0, 6)) - 3));
        sb[k][3*i +: 3] = 3'($signed(int'($urandom_range(0, 6)) - 3));
      end
    end
    for (int k = 0; k < 10; k++) begin
      if (k >= 2) check_result(sa[k-2], sb[k-2], "R6 stream");
      if (k < 8) begin in_a = sa[k]; in_b = sb[k]; in_valid = 1'b1; end
      else in_valid = 1'b0;
      @(negedge clk);
    end
    check(out_valid == 1'b0, "R6", "stream drained", out_valid, 0);
  endtask

  task automatic t_idle_hold();
    logic [OW-1:0] held;
    apply(put(1, 3), put(1, 2), "R9 setup");
    held = out_sum;
    for (int k = 0; k < 5; k++) begin
      in_valid = 1'b0;
      in_a = IW'($urandom); in_b = IW'($urandom);
      @(negedge clk);
      if (k >= 1) begin
        check(out_sum == held, "R9", "idle hold sum", out_sum, held);
        check(out_valid == 1'b0, "R9", "idle no valid", out_valid, 0);
      end
    end
  endtask

  task automatic t_illegal();
    in_a = put(2, -4); in_b = put(0, 1); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b1, "R8", "illegal valid", out_valid, 1);
    check(out_bad == 1'b1, "R8", "illegal in a flagged", out_bad, 1);
    in_a = put(0, 2); in_b = put(3, -4); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_bad == 1'b1, "R8", "illegal in b flagged", out_bad, 1);
    apply(put(0, 2), put(3, 3), "R8 legal after");
  endtask

  task automatic t_midrun_reset();
    in_a = put(0, 3); in_b = put(0, 3); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    #3 rst_n = 1'b0;
    #2;
    check(out_valid == 1'b0, "R7", "async reset valid", out_valid, 0);
    check(out_sum == '0, "R7", "async reset sum", out_sum, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "post reset valid", out_valid, 0);
  endtask

  initial begin
    t_reset();
    t_directed();
    t_exhaustive();
    t_random();
    t_stream();
    t_idle_hold();
    t_illegal();
    t_midrun_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule